// File: doc/BRIEF.md
# Shared-Function GPIO Port Controller

This block manages a bank of general-purpose pins inside a small microcontroller, where every pin is shared between the LCD segment driver and a software-controlled I/O function. A programmable LCD pin count decides ownership: pins whose index falls below the count belong to the LCD driver, and the rest are general I/O. Each I/O pin has a direction bit and a data bit. Software reaches both, together with the count and an override control register, over a simple register bus.

Three fixed alternate functions can take selected pins away from the data path. A serial-memory enable hands pin 4 to the serial clock and pin 5 to an open-drain bidirectional data line. Two pulse enables route the watt and VAR metering pulses onto pins 6 and 7, provided that pin's direction bit selects output. Each override applies only while the LCD pin count stays below its own limit. An active override takes priority over both the LCD driver and the data bit. Pin levels are read back through a two-flop synchronizer.

The register bus and the pad signals carry no stream of data, so they stay plain level signals with no valid/ready handshake. A write completes on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gsp_port`

## Requirements
- R1: After reset every register holds zero except the reserved direction bits. With a count of zero every pin is an input (`pin_oe` all zero), and registers 3, 4, 6 and 7 read 0x00.
- R2: On a general I/O pin, a direction bit of 1 makes the pin an output (`pin_oe`=1, `pin_out` = data bit) and 0 makes it an input (`pin_oe`=0). Pins 0–7 use bit i of data register 0 and direction register 3. Pins 8–15 use registers 1 and 4. Pins 16–17 use bits 1:0 of registers 2 and 5.
- R3: A pin whose index is below the LCD pin count (register 6) is LCD-owned. It drives `lcd_seg[i]` with `pin_oe`=1, and its direction bit has no effect.
- R4: A read of a data register returns the synchronized pin level, which appears on the bus two clock edges after the pad changes. LCD-owned pins read 0.
- R5: A data-register write changes only the bits of general I/O pins whose direction is output. Bits for input or LCD-owned pins keep their stored value.
- R6: Bits 7:2 of direction register 5 are reserved. They always read 1 and ignore writes.
- R7: When control bit 0 (register 7) is set and the count is below 18, pin 4 drives `mem_scl` with `pin_oe`=1. Pin 5 is then open drain: it is driven low only while `mem_sda_o`=0 and released otherwise. `mem_sda_i` always follows the pin 5 pad level.
- R8: When control bit 1 is set, the count is below 17 and direction bit 6 is 1, pin 6 drives `watt_pulse`.
- R9: When control bit 2 is set, the count is below 15 and direction bit 7 is 1, pin 7 drives `var_pulse`.
- R10: Register 6 reads back the LCD pin count. Register 7 reads back the three control bits in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 18 | Pad input levels |
| pin_out | output | 18 | Pad output values |
| pin_oe | output | 18 | Pad output enables |
| lcd_seg | input | 18 | Segment drive from the LCD driver |
| mem_scl | input | 1 | Serial memory clock from the engine |
| mem_sda_o | input | 1 | Serial memory data request (0 pulls low) |
| mem_sda_i | output | 1 | Serial memory data pad level |
| watt_pulse | input | 1 | Watt pulse signal |
| var_pulse | input | 1 | VAR pulse signal |

## Verification
A vector table sweeps LCD counts of 0, 3, 5 and 8 across mixed direction, data and pad patterns. It checks that ownership, direction and pad level each decide the right bits of `pin_oe` and the read value. Directed tests put each override exactly on its count limit and one below it, which separates a correct limit from an off-by-one one. They also set the data bit to the opposite of the alternate signal, so a missing override shows up. Writes to input and LCD pins are followed by turning those pins into outputs, which exposes any stored value that changed. A single pad toggle measures the two-edge read latency.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  // override control register layout, bit 0 = serial memory
  typedef struct packed {
    logic var_en;
    logic watt_en;
    logic smem_en;
  } ovr_ctrl_t;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R4
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gsp_regs.sv
module gsp_regs
  import gsp_pkg::*;
#(
  parameter int NPIN   = 18,
  parameter int NBANK  = 3,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic [NPIN-1:0]   lcd_own,
  output logic [NPIN-1:0]   data_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [CNT_W-1:0]  lcd_cnt,
  output ovr_ctrl_t         ctrl
);
  localparam int DIR_BASE = NBANK;
  localparam int CNT_ADDR = 2 * NBANK;
  localparam int CTL_ADDR = 2 * NBANK + 1;
  localparam int LAST_W   = NPIN - 8 * (NBANK - 1);

  logic [NPIN-1:0] io_out;
  assign io_out = ~lcd_own & dir_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    localparam int B = i / 8;
    localparam int J = i % 8;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[i] <= 1'b0;
      else if (bus_wr && bus_addr == ADDR_W'(B) && io_out[i]) data_q[i] <= bus_wdata[J];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q[i] <= 1'b0;
      else if (bus_wr && bus_addr == ADDR_W'(DIR_BASE + B)) dir_q[i] <= bus_wdata[J];
    end

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(B) && !io_out[i]) |=> $stable(data_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcd_cnt <= '0;
      ctrl    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(CNT_ADDR)) lcd_cnt <= bus_wdata[CNT_W-1:0];
      if (bus_addr == ADDR_W'(CTL_ADDR)) ctrl <= ovr_ctrl_t'(bus_wdata[2:0]);
    end
  end

  logic [NBANK*8-1:0] rd_data_v, rd_dir_v;
  always_comb begin
    rd_data_v = '0;
    rd_dir_v  = '1;
    rd_data_v[NPIN-1:0] = pin_lvl & ~lcd_own;
    rd_dir_v[NPIN-1:0]  = dir_q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == ADDR_W'(b))            bus_rdata = rd_data_v[b*8 +: 8];
      if (bus_addr == ADDR_W'(DIR_BASE + b)) bus_rdata = rd_dir_v[b*8 +: 8];
    end
    if (bus_addr == ADDR_W'(CNT_ADDR)) bus_rdata = 8'(lcd_cnt);
    if (bus_addr == ADDR_W'(CTL_ADDR)) bus_rdata = 8'(ctrl);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dir_q == '0 && data_q == '0 && lcd_cnt == '0));

  if (LAST_W < 8) begin : g_rsv
    // R6
    rsv_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(DIR_BASE + NBANK - 1)) |-> (&bus_rdata[7:LAST_W]));
  end
endmodule

// File: rtl/gsp_pinmux.sv
module gsp_pinmux
  import gsp_pkg::*;
#(
  parameter int NPIN     = 18,
  parameter int CNT_W    = 5,
  parameter int SCL_PIN  = 4,
  parameter int SDA_PIN  = 5,
  parameter int WATT_PIN = 6,
  parameter int VAR_PIN  = 7,
  parameter int SMEM_LIM = 18,
  parameter int WATT_LIM = 17,
  parameter int VAR_LIM  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lcd_cnt,
  input  ovr_ctrl_t        ctrl,
  input  logic [NPIN-1:0]  data_q,
  input  logic [NPIN-1:0]  dir_q,
  input  logic [NPIN-1:0]  lcd_seg,
  input  logic             mem_scl,
  input  logic             mem_sda_o,
  input  logic             watt_pulse,
  input  logic             var_pulse,
  output logic [NPIN-1:0]  lcd_own,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe
);
  logic smem_act, watt_act, var_act;
  assign smem_act = ctrl.smem_en && (lcd_cnt < CNT_W'(SMEM_LIM));
  assign watt_act = ctrl.watt_en && (lcd_cnt < CNT_W'(WATT_LIM)) && dir_q[WATT_PIN];
  assign var_act  = ctrl.var_en  && (lcd_cnt < CNT_W'(VAR_LIM))  && dir_q[VAR_PIN];

  logic [NPIN-1:0] base_out, base_oe;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign lcd_own[i]  = CNT_W'(i) < lcd_cnt;
    assign base_oe[i]  = lcd_own[i] | dir_q[i];
    assign base_out[i] = lcd_own[i] ? lcd_seg[i] : data_q[i];

    if (i == SCL_PIN) begin : g_scl
      assign pin_oe[i]  = smem_act | base_oe[i];
      assign pin_out[i] = smem_act ? mem_scl : base_out[i];
    end else if (i == SDA_PIN) begin : g_sda
      assign pin_oe[i]  = smem_act ? ~mem_sda_o : base_oe[i];
      assign pin_out[i] = smem_act ? 1'b0 : base_out[i];
    end else if (i == WATT_PIN) begin : g_watt
      assign pin_oe[i]  = watt_act | base_oe[i];
      assign pin_out[i] = watt_act ? watt_pulse : base_out[i];
    end else if (i == VAR_PIN) begin : g_var
      assign pin_oe[i]  = var_act | base_oe[i];
      assign pin_out[i] = var_act ? var_pulse : base_out[i];
    end else begin : g_plain
      assign pin_oe[i]  = base_oe[i];
      assign pin_out[i] = base_out[i];
    end
  end

  // R7
  sda_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smem_act |-> !(pin_oe[SDA_PIN] && pin_out[SDA_PIN]));

  // R8
  watt_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    watt_act |-> pin_oe[WATT_PIN]);

  // R9
  var_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    var_act |-> pin_oe[VAR_PIN]);
endmodule

// File: rtl/gsp_port.sv
module gsp_port
  import gsp_pkg::*;
#(
  parameter int NPIN = 18,
  localparam int NBANK  = (NPIN + 7) / 8,
  localparam int CNT_W  = $clog2(NPIN + 1),
  localparam int ADDR_W = $clog2(2 * NBANK + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  input  logic [NPIN-1:0]   lcd_seg,
  input  logic              mem_scl,
  input  logic              mem_sda_o,
  output logic              mem_sda_i,
  input  logic              watt_pulse,
  input  logic              var_pulse
);
  localparam int SDA_PIN = 5;

  logic [NPIN-1:0]  pin_lvl, lcd_own, data_q, dir_q;
  logic [CNT_W-1:0] lcd_cnt;
  ovr_ctrl_t        ctrl;

  assign mem_sda_i = pin_in[SDA_PIN];

  gsp_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_lvl)
  );

  gsp_regs #(.NPIN(NPIN), .NBANK(NBANK), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(pin_lvl),
    .lcd_own(lcd_own), .data_q(data_q), .dir_q(dir_q),
    .lcd_cnt(lcd_cnt), .ctrl(ctrl)
  );

  gsp_pinmux #(.NPIN(NPIN), .CNT_W(CNT_W), .SDA_PIN(SDA_PIN)) u_mux (
    .clk(clk), .rst_n(rst_n), .lcd_cnt(lcd_cnt), .ctrl(ctrl),
    .data_q(data_q), .dir_q(dir_q), .lcd_seg(lcd_seg),
    .mem_scl(mem_scl), .mem_sda_o(mem_sda_o), .watt_pulse(watt_pulse),
    .var_pulse(var_pulse), .lcd_own(lcd_own), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: tb/tb_gsp_port.sv
module tb_gsp_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [17:0] pin_in, pin_out, pin_oe;
  logic [17:0] lcd_seg = '0;
  logic [17:0] ext = '0;
  logic        mem_scl = 1'b0, mem_sda_o = 1'b1, mem_sda_i;
  logic        watt_pulse = 1'b0, var_pulse = 1'b0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gsp_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .lcd_seg(lcd_seg),
    .mem_scl(mem_scl), .mem_sda_o(mem_sda_o), .mem_sda_i(mem_sda_i),
    .watt_pulse(watt_pulse), .var_pulse(var_pulse)
  );

  // {lcd count, direction, data, pad drive, expected oe[7:0], expected read}
  localparam logic [47:0] VEC [5] = '{
    {8'd0, 8'h00, 8'hAA, 8'h5C, 8'h00, 8'h5C},
    {8'd0, 8'hF0, 8'hA5, 8'h0F, 8'hF0, 8'hAF},
    {8'd3, 8'h0F, 8'h3C, 8'hF0, 8'h0F, 8'hF8},
    {8'd8, 8'h55, 8'hFF, 8'hFF, 8'hFF, 8'h00},
    {8'd5, 8'hC0, 8'h80, 8'h3F, 8'hDF, 8'hA0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", 32'(pin_oe), 32'h0);
    rd(3, r); check("R1 dir0", 32'(r), 32'h00);
    rd(4, r); check("R1 dir1", 32'(r), 32'h00);
    rd(5, r); check("R6 reset dir2", 32'(r), 32'hFC);
    rd(6, r); check("R1 count", 32'(r), 32'h00);
    rd(7, r); check("R1 ctrl", 32'(r), 32'h00);

    // R2 R3 R4 table
    for (int k = 0; k < 5; k++) begin
      wr(6, 8'd0);
      wr(3, 8'hFF);
      wr(0, VEC[k][31:24]);
      wr(3, VEC[k][39:32]);
      wr(6, VEC[k][47:40]);
      ext[7:0] = VEC[k][23:16];
      repeat (3) @(negedge clk);
      check("R2/R3 oe vector", 32'(pin_oe[7:0]), 32'(VEC[k][15:8]));
      rd(0, r); check("R4 read vector", 32'(r), 32'(VEC[k][7:0]));
    end

    // R4 two-edge latency
    wr(6, 8'd0); wr(3, 8'h00);
    ext[7:0] = 8'h00;
    repeat (3) @(negedge clk);
    ext[0] = 1'b1;
    @(negedge clk);
    rd(0, r); check("R4 after one edge", 32'(r[0]), 32'h0);
    @(negedge clk);
    rd(0, r); check("R4 after two edges", 32'(r[0]), 32'h1);

    // R5 writes to input and LCD pins ignored (stored 0x80)
    wr(0, 8'hFF);
    wr(3, 8'hFF);
    check("R5 input write ignored", 32'(pin_out[7:0]), 32'h80);
    wr(6, 8'd8); wr(0, 8'h00); wr(6, 8'd0);
    check("R5 LCD write ignored", 32'(pin_out[7:0]), 32'h80);
    wr(0, 8'h3C);
    check("R2 output write", 32'(pin_out[7:0]), 32'h3C);

    // R6 reserved bits
    wr(5, 8'h00); rd(5, r); check("R6 write zero", 32'(r), 32'hFC);
    wr(5, 8'h01); rd(5, r); check("R6 low bits", 32'(r), 32'hFD);
    wr(5, 8'h00);

    // R7 serial memory
    wr(7, 8'h01);
    mem_scl = 1'b0; mem_sda_o = 1'b0;
    #1;
    check("R7 scl", 32'({pin_oe[4], pin_out[4]}), 32'h2);
    check("R7 sda low", 32'({pin_oe[5], pin_out[5]}), 32'h2);
    mem_sda_o = 1'b1; ext[5] = 1'b1; #1;
    check("R7 sda released", 32'({pin_oe[5], mem_sda_i}), 32'h1);
    ext[5] = 1'b0; #1;
    check("R7 sda in low", 32'(mem_sda_i), 32'h0);
    lcd_seg[4] = 1'b1;
    wr(6, 8'd18);
    check("R7 limit 18 off", 32'(pin_out[4]), 32'h1);
    wr(6, 8'd17);
    check("R7 limit 17 on", 32'(pin_out[4]), 32'h0);
    lcd_seg[4] = 1'b0;
    wr(7, 8'h00); wr(6, 8'd0);

    // R8 watt pulse on pin 6 (data bit 6 is 0)
    wr(7, 8'h02);
    watt_pulse = 1'b1; #1;
    check("R8 watt on", 32'(pin_out[6]), 32'h1);
    wr(6, 8'd17);
    check("R8 limit 17 off", 32'(pin_out[6]), 32'h0);
    wr(6, 8'd16);
    check("R8 limit 16 on", 32'(pin_out[6]), 32'h1);
    wr(6, 8'd0); wr(3, 8'hBF);
    check("R8 needs output dir", 32'(pin_oe[6]), 32'h0);
    wr(3, 8'hFF); watt_pulse = 1'b0;

    // R9 var pulse on pin 7 (data bit 7 is 0)
    wr(7, 8'h04);
    var_pulse = 1'b1; #1;
    check("R9 var on", 32'(pin_out[7]), 32'h1);
    wr(6, 8'd14);
    check("R9 limit 14 on", 32'(pin_out[7]), 32'h1);
    wr(6, 8'd15);
    check("R9 limit 15 off", 32'(pin_out[7]), 32'h0);

    // R10 readback
    rd(6, r); check("R10 count", 32'(r), 32'd15);
    rd(7, r); check("R10 ctrl", 32'(r), 32'h04);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule